// File: doc/BRIEF.md
# Triggered ADC Window Capture Pipeline

This block sits behind one digitizer channel. It takes a 12-bit sample on every clock and writes it into a circular memory of `DEPTH` samples, with no gaps. The default depth of 2048 covers 8 µs at a 4 ns sample period. Recording does not pause while triggers are served. The trigger decision is made later than the event, so a trigger strobe marks a point in time. The block then looks back a programmable number of samples and pulls a window of history out of the memory.

Each accepted trigger becomes one job in a small queue. A single engine processes the jobs one at a time. In raw mode it streams the window's samples. In sum mode it reports one pedestal-corrected, saturated charge value. In time mode it reports the position of the first sample at or above a threshold. Every output word carries a type tag and a running trigger number, and it leaves through a valid/ready stream.

Configuration rules for defined results: 1 ≤ `cfg_width` ≤ `cfg_lat`, and `cfg_lat` plus the queued work fits inside `DEPTH` samples. Configuration stays constant while jobs are outstanding. `DEPTH` must be a power of two.

Top module: `adc_trig_pipe`

## Requirements
- R1: Sample index n counts the clock edges since reset was released, starting at 0. A trigger seen on the same edge as sample n selects samples n−`cfg_lat` through n−`cfg_lat`+`cfg_width`−1, oldest first. Samples keep being recorded during readout.
- R2: With `cfg_mode`=0 (code 3 acts the same), the block emits `cfg_width` words with `out_tag`=1. Each `out_payload` is the sample zero-extended to 20 bits, in window order, and `out_last` is high only on the final word.
- R3: With `cfg_mode`=1, the block emits one word with `out_tag`=2 and `out_last`=1. Its payload is the sum of the window samples minus `cfg_ped`×`cfg_width`, as 20-bit two's complement.
- R4: The sum is saturated to the range −524288 to +524287. Those limits appear as 0x80000 and 0x7FFFF.
- R5: With `cfg_mode`=2, the block emits one word with `out_tag`=3 and `out_last`=1. Its payload is the 0-based index of the first window sample whose value is greater than or equal to `cfg_thr`.
- R6: In time mode, a window with no sample at or above `cfg_thr` reports 0xFFF.
- R7: `out_tnum` is 0 for the first accepted trigger after reset and rises by one for each accepted trigger. All words of one trigger carry the same number.
- R8: While the engine works on one job, up to `QDEPTH` (4) further triggers wait in order. A trigger that arrives when `QDEPTH` are already waiting is dropped, produces no output and uses no number. It also sets `ovf`, which stays high until reset.
- R9: While `out_valid` is high and `out_ready` is low, the word and its tag, number and last flag hold steady. No word is lost or repeated.
- R10: During and right after reset, `out_valid` and `ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 12 | ADC sample, one per clock |
| trig | input | 1 | Trigger strobe, one trigger per high cycle |
| cfg_mode | input | 2 | 0 raw, 1 sum, 2 time |
| cfg_lat | input | 11 | Lookback in samples |
| cfg_width | input | 11 | Window length in samples |
| cfg_ped | input | 12 | Pedestal per sample for sum mode |
| cfg_thr | input | 12 | Threshold for time mode |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts word |
| out_tag | output | 2 | Word type: 1 raw, 2 sum, 3 time |
| out_tnum | output | 8 | Trigger number |
| out_payload | output | 20 | Sample, sum or time index |
| out_last | output | 1 | Final word of a trigger |
| ovf | output | 1 | Sticky trigger-drop flag |

## Verification
Three things can land in one clock: a new trigger pushed into the queue, the engine popping the oldest job, and the ring overwriting history. The sharpest collision is a trigger that meets a full queue while the engine is stalled by a low `out_ready`. The bench provokes it with a burst of triggers on consecutive cycles while the engine holds an unaccepted sum word. The bench then judges the result at the ports. It expects exactly four queued results with consecutive numbers and correct sums for their own sample indices, a set `ovf`, and no words for the dropped strobes. Raw readouts under a periodic stall confirm that the engine still reads the window correctly while recording continues.

// File: rtl/adc_pipe_pkg.sv
package adc_pipe_pkg;

    typedef enum logic [1:0] {
        MODE_RAW  = 2'd0,
        MODE_SUM  = 2'd1,
        MODE_TIME = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        TAG_NONE = 2'd0,
        TAG_RAW  = 2'd1,
        TAG_SUM  = 2'd2,
        TAG_TIME = 2'd3
    } word_tag_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_EMIT = 2'd2
    } eng_state_e;

    localparam int NO_HIT = 'hFFF;

    function automatic rd_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd1:    return MODE_SUM;
            2'd2:    return MODE_TIME;
            default: return MODE_RAW;
        endcase
    endfunction

    function automatic word_tag_e tag_of(input rd_mode_e m);
        case (m)
            MODE_SUM:  return TAG_SUM;
            MODE_TIME: return TAG_TIME;
            default:   return TAG_RAW;
        endcase
    endfunction

endpackage

// File: rtl/adc_ring_buf.sv
module adc_ring_buf #(
    parameter int SW = 12,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] wr_data,
    output logic [AW-1:0] wr_ptr,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [SW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [SW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) wr_ptr <= '0;
        else     wr_ptr <= wr_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        mem[wr_ptr] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/trig_queue.sv
module trig_queue #(
    parameter int EW     = 19,
    parameter int QDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [EW-1:0] push_data,
    input  logic          pop,
    output logic [EW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic          ovf
);
    localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int CNT_W = $clog2(QDEPTH + 1);

    logic [EW-1:0]    slots [QDEPTH];
    logic [PTR_W-1:0] rd_p, wr_p;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(QDEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_p];

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_p] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
            ovf  <= 1'b0;
        end else begin
            if (do_push) wr_p <= nxt(wr_p);
            if (do_pop)  rd_p <= nxt(rd_p);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (push && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/win_engine.sv
module win_engine
    import adc_pipe_pkg::*;
#(
    parameter int SW  = 12,
    parameter int AW  = 11,
    parameter int TNW = 8,
    parameter int PW  = 20
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           q_empty,
    input  logic [AW-1:0]  q_start,
    input  logic [TNW-1:0] q_tnum,
    output logic           q_pop,
    input  logic [1:0]     cfg_mode,
    input  logic [AW-1:0]  cfg_width,
    input  logic [SW-1:0]  cfg_ped,
    input  logic [SW-1:0]  cfg_thr,
    output logic           rd_en,
    output logic [AW-1:0]  rd_addr,
    input  logic [SW-1:0]  rd_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [1:0]     out_tag,
    output logic [TNW-1:0] out_tnum,
    output logic [PW-1:0]  out_payload,
    output logic           out_last
);
    localparam int ACC_W  = SW + AW + 2;
    localparam int SAT_HI = (1 << (PW - 1)) - 1;
    localparam int SAT_LO = -(1 << (PW - 1));

    eng_state_e               state;
    rd_mode_e                 mode_r;
    logic [AW-1:0]            width_r, rd_ptr, iss_cnt, proc_cnt, hit_idx;
    logic [SW-1:0]            ped_r, thr_r;
    logic                     d_v, hit_found;
    logic signed [ACC_W-1:0]  acc, acc_nx, smp_s, ped_s;
    logic                     issue, last_smp, crosses;
    logic [PW-1:0]            sat_val, time_val;

    // job intake and read issue
    assign q_pop    = (state == S_IDLE) && !q_empty;
    assign issue    = (state == S_RUN) && (iss_cnt != width_r)
                      && ((mode_r != MODE_RAW) || !d_v);
    assign rd_en    = issue;
    assign rd_addr  = rd_ptr;
    assign last_smp = (proc_cnt == width_r - 1'b1);
    assign out_tag  = tag_of(mode_r);
    assign out_tnum = tnum_r;

    logic [TNW-1:0] tnum_r;

    // arithmetic on the returning sample
    always_comb begin
        smp_s   = {{(ACC_W-SW){1'b0}}, rd_data};
        ped_s   = {{(ACC_W-SW){1'b0}}, ped_r};
        acc_nx  = acc + smp_s - ped_s;
        crosses = (rd_data >= thr_r);
        if (acc_nx > ACC_W'(SAT_HI))      sat_val = PW'(SAT_HI);
        else if (acc_nx < ACC_W'(SAT_LO)) sat_val = PW'(SAT_LO);
        else                              sat_val = acc_nx[PW-1:0];
        if (hit_found)    time_val = PW'(hit_idx);
        else if (crosses) time_val = PW'(proc_cnt);
        else              time_val = PW'(NO_HIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            mode_r      <= MODE_RAW;
            width_r     <= '0;
            ped_r       <= '0;
            thr_r       <= '0;
            tnum_r      <= '0;
            rd_ptr      <= '0;
            iss_cnt     <= '0;
            proc_cnt    <= '0;
            hit_idx     <= '0;
            hit_found   <= 1'b0;
            acc         <= '0;
            d_v         <= 1'b0;
            out_valid   <= 1'b0;
            out_last    <= 1'b0;
            out_payload <= '0;
        end else begin
            d_v <= issue;
            if (issue) begin
                rd_ptr  <= rd_ptr + 1'b1;
                iss_cnt <= iss_cnt + 1'b1;
            end
            case (state)
                S_IDLE: begin
                    if (!q_empty) begin
                        mode_r    <= decode_mode(cfg_mode);
                        width_r   <= cfg_width;
                        ped_r     <= cfg_ped;
                        thr_r     <= cfg_thr;
                        tnum_r    <= q_tnum;
                        rd_ptr    <= q_start;
                        iss_cnt   <= '0;
                        proc_cnt  <= '0;
                        acc       <= '0;
                        hit_found <= 1'b0;
                        state     <= S_RUN;
                    end
                end
                S_RUN: begin
                    if (d_v) begin
                        proc_cnt <= proc_cnt + 1'b1;
                        case (mode_r)
                            MODE_RAW: begin
                                out_payload <= PW'(rd_data);
                                out_last    <= last_smp;
                                out_valid   <= 1'b1;
                                state       <= S_EMIT;
                            end
                            MODE_SUM: begin
                                acc <= acc_nx;
                                if (last_smp) begin
                                    out_payload <= sat_val;
                                    out_last    <= 1'b1;
                                    out_valid   <= 1'b1;
                                    state       <= S_EMIT;
                                end
                            end
                            default: begin
                                if (!hit_found && crosses) begin
                                    hit_found <= 1'b1;
                                    hit_idx   <= proc_cnt;
                                end
                                if (last_smp) begin
                                    out_payload <= time_val;
                                    out_last    <= 1'b1;
                                    out_valid   <= 1'b1;
                                    state       <= S_EMIT;
                                end
                            end
                        endcase
                    end
                end
                default: begin
                    if (out_ready) begin
                        out_valid <= 1'b0;
                        state     <= out_last ? S_IDLE : S_RUN;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_trig_pipe.sv
module adc_trig_pipe
    import adc_pipe_pkg::*;
#(
    parameter int SMP_W  = 12,
    parameter int DEPTH  = 2048,
    parameter int QDEPTH = 4,
    parameter int TNUM_W = 8,
    parameter int PAY_W  = 20,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SMP_W-1:0]  smp_in,
    input  logic              trig,
    input  logic [1:0]        cfg_mode,
    input  logic [AW-1:0]     cfg_lat,
    input  logic [AW-1:0]     cfg_width,
    input  logic [SMP_W-1:0]  cfg_ped,
    input  logic [SMP_W-1:0]  cfg_thr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_tag,
    output logic [TNUM_W-1:0] out_tnum,
    output logic [PAY_W-1:0]  out_payload,
    output logic              out_last,
    output logic              ovf
);
    typedef struct packed {
        logic [AW-1:0]     start;
        logic [TNUM_W-1:0] tnum;
    } trig_ent_t;

    logic [AW-1:0]     wr_ptr, rd_addr;
    logic [SMP_W-1:0]  rd_data;
    logic              rd_en, q_pop, q_empty, q_full;
    logic [TNUM_W-1:0] tnum_ctr;
    trig_ent_t         new_ent, head_ent;

    always_comb begin
        new_ent.start = wr_ptr - cfg_lat;
        new_ent.tnum  = tnum_ctr;
    end

    always_ff @(posedge clk) begin
        if (rst)                  tnum_ctr <= '0;
        else if (trig && !q_full) tnum_ctr <= tnum_ctr + 1'b1;
    end

    adc_ring_buf #(.SW(SMP_W), .AW(AW)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_data (smp_in),
        .wr_ptr  (wr_ptr),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    trig_queue #(.EW($bits(trig_ent_t)), .QDEPTH(QDEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (trig),
        .push_data (new_ent),
        .pop       (q_pop),
        .head      (head_ent),
        .empty     (q_empty),
        .full      (q_full),
        .ovf       (ovf)
    );

    win_engine #(.SW(SMP_W), .AW(AW), .TNW(TNUM_W), .PW(PAY_W)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .q_empty     (q_empty),
        .q_start     (head_ent.start),
        .q_tnum      (head_ent.tnum),
        .q_pop       (q_pop),
        .cfg_mode    (cfg_mode),
        .cfg_width   (cfg_width),
        .cfg_ped     (cfg_ped),
        .cfg_thr     (cfg_thr),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_tag     (out_tag),
        .out_tnum    (out_tnum),
        .out_payload (out_payload),
        .out_last    (out_last)
    );
endmodule

// File: rtl/adc_pipe_chk.sv
module adc_pipe_chk #(
    parameter int SW  = 12,
    parameter int AW  = 11,
    parameter int TNW = 8,
    parameter int PW  = 20
) (
    input logic           clk,
    input logic           rst,
    input logic           trig,
    input logic [AW-1:0]  cfg_width,
    input logic           out_valid,
    input logic           out_ready,
    input logic [1:0]     out_tag,
    input logic [TNW-1:0] out_tnum,
    input logic [PW-1:0]  out_payload,
    input logic           out_last,
    input logic           ovf
);
    logic           seen;
    logic [TNW-1:0] nxt_tnum;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen     <= 1'b0;
            nxt_tnum <= '0;
        end else if (out_valid && out_ready && out_last) begin
            seen     <= 1'b1;
            nxt_tnum <= out_tnum + 1'b1;
        end
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)
            && $stable(out_tnum) && $stable(out_tag) && $stable(out_last)));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(trig));

    // R5
    time_range_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_tag == 2'd3) |->
            (out_payload == PW'('hFFF) || out_payload < PW'(cfg_width)));

    // R2
    raw_width_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_tag == 2'd1) |-> (out_payload[PW-1:SW] == '0));

    // R7
    tnum_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last && seen) |-> (out_tnum == nxt_tnum));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !ovf));
endmodule

bind adc_trig_pipe adc_pipe_chk #(
    .SW(SMP_W), .AW(AW), .TNW(TNUM_W), .PW(PAY_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .trig        (trig),
    .cfg_width   (cfg_width),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_tag     (out_tag),
    .out_tnum    (out_tnum),
    .out_payload (out_payload),
    .out_last    (out_last),
    .ovf         (ovf)
);

// File: tb/tb_adc_trig_pipe.sv
module tb_adc_trig_pipe;
    localparam int AW  = 11;
    localparam int TNW = 8;
    localparam int PW  = 20;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [11:0]    smp_in = '0;
    logic           trig = 1'b0;
    logic [1:0]     cfg_mode = '0;
    logic [AW-1:0]  cfg_lat = '0;
    logic [AW-1:0]  cfg_width = 11'd1;
    logic [11:0]    cfg_ped = '0;
    logic [11:0]    cfg_thr = '0;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic [1:0]     out_tag;
    logic [TNW-1:0] out_tnum;
    logic [PW-1:0]  out_payload;
    logic           out_last;
    logic           ovf;

    int checks = 0;
    int errors = 0;
    int n_cur  = 0;
    int pat    = 0;
    int cval   = 0;
    int cyc    = 0;
    int exp_tnum = 0;
    bit bp     = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_trig_pipe dut (
        .clk(clk), .rst(rst), .smp_in(smp_in), .trig(trig),
        .cfg_mode(cfg_mode), .cfg_lat(cfg_lat), .cfg_width(cfg_width),
        .cfg_ped(cfg_ped), .cfg_thr(cfg_thr),
        .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
        .out_tnum(out_tnum), .out_payload(out_payload), .out_last(out_last),
        .ovf(ovf)
    );

    function automatic int smp(input int n);
        return (pat == 0) ? ((n * 37 + 11) % 4096) : cval;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_samples();
        int n = 0;
        forever begin
            smp_in = 12'(smp(n));
            n_cur  = n;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic fire(output int tn);
        @(negedge clk); #1;
        trig = 1'b1;
        tn   = n_cur;
        @(negedge clk); #1;
        trig = 1'b0;
    endtask

    task automatic get_word(output int tg, output int tnm, output int pay,
                            output bit lst, output bit ok);
        ok = 1'b0; tg = 0; tnm = 0; pay = 0; lst = 1'b0;
        for (int w = 0; w < 6000; w++) begin
            bit rdy;
            @(negedge clk); #2;
            rdy = bp ? ((cyc % 3) != 0) : 1'b1;
            out_ready = rdy;
            if (out_valid && rdy) begin
                tg  = int'(out_tag);
                tnm = int'(out_tnum);
                pay = int'(out_payload);
                lst = out_last;
                ok  = 1'b1;
                break;
            end
        end
    endtask

    task automatic stop_ready();
        @(negedge clk); #2;
        out_ready = 1'b0;
    endtask

    function automatic int exp_sum(input int tn, input int lat, input int w, input int ped);
        int s = 0;
        for (int i = 0; i < w; i++) s += smp(tn - lat + i) - ped;
        if (s > 524287)  s = 524287;
        if (s < -524288) s = -524288;
        return s & 'hFFFFF;
    endfunction

    function automatic int exp_time(input int tn, input int lat, input int w, input int thr);
        for (int i = 0; i < w; i++) if (smp(tn - lat + i) >= thr) return i;
        return 'hFFF;
    endfunction

    task automatic check_one(input int mode, input int tn, input int lat, input int w,
                             input int ped, input int thr, input string req);
        int tg, tnm, pay; bit lst, ok;
        get_word(tg, tnm, pay, lst, ok);
        chk(ok, {req, " word present"}, int'(ok), 1);
        chk(tnm == (exp_tnum & 'hFF), "R7 trigger number", tnm, exp_tnum & 'hFF);
        chk(lst, {req, " last flag"}, int'(lst), 1);
        if (mode == 1) begin
            chk(tg == 2, "R3 sum tag", tg, 2);
            chk(pay == exp_sum(tn, lat, w, ped), req, pay, exp_sum(tn, lat, w, ped));
        end else begin
            chk(tg == 3, "R5 time tag", tg, 3);
            chk(pay == exp_time(tn, lat, w, thr), req, pay, exp_time(tn, lat, w, thr));
        end
    endtask

    task automatic run_case(input int mode, input int lat, input int w,
                            input int ped, input int thr, input string req);
        int tn;
        @(negedge clk); #1;
        cfg_mode  = 2'(mode);
        cfg_lat   = AW'(lat);
        cfg_width = AW'(w);
        cfg_ped   = 12'(ped);
        cfg_thr   = 12'(thr);
        fire(tn);
        if (mode == 0) begin
            for (int i = 0; i < w; i++) begin
                int tg, tnm, pay; bit lst, ok;
                get_word(tg, tnm, pay, lst, ok);
                chk(ok, "R2 raw word present", int'(ok), 1);
                chk(tg == 1, "R2 raw tag", tg, 1);
                chk(tnm == (exp_tnum & 'hFF), "R7 trigger number", tnm, exp_tnum & 'hFF);
                // R1: sample n-lat+i of the recorded stream
                chk(pay == smp(tn - lat + i), "R1 window sample", pay, smp(tn - lat + i));
                chk(lst == (i == w - 1), "R2 last flag", int'(lst), int'(i == w - 1));
            end
        end else begin
            check_one(mode, tn, lat, w, ped, thr, req);
        end
        stop_ready();
        exp_tnum++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lats [4] = '{3, 8, 40, 200};
        int t0;
        int tb_n [6];
        repeat (4) @(negedge clk);
        #2;
        // R10 reset state
        chk(!out_valid, "R10 valid in reset", int'(out_valid), 0);
        chk(!ovf, "R10 ovf in reset", int'(ovf), 0);
        @(negedge clk);
        rst = 1'b0;
        fork
            drive_samples();
        join_none
        @(negedge clk); #2;
        chk(!out_valid, "R10 valid after reset", int'(out_valid), 0);
        repeat (300) @(negedge clk);

        // sweep: modes x lookback x width
        for (int li = 0; li < 4; li++) begin
            for (int wi = 0; wi < 3; wi++) begin
                int w;
                w  = (wi == 0) ? 1 : (wi == 1) ? 2 : lats[li];
                bp = (lats[li] == 8) || (lats[li] == 200);
                run_case(0, lats[li], w, 0, 0, "R2 raw");
                run_case(1, lats[li], w, 500, 0, "R3 sum");
                run_case(2, lats[li], w, 0, 2000, "R5 time");
            end
        end
        bp = 1'b0;

        // saturation and exact edge, constant input
        pat = 1; cval = 4095;
        repeat (300) @(negedge clk);
        run_case(1, 200, 128, 0, 0, "R3 sum below limit");
        run_case(1, 200, 129, 0, 0, "R4 positive saturation");
        run_case(1, 200, 200, 0, 0, "R4 positive saturation");
        cval = 0;
        repeat (300) @(negedge clk);
        run_case(1, 200, 200, 4095, 0, "R4 negative saturation");
        cval = 100;
        repeat (300) @(negedge clk);
        run_case(2, 50, 20, 0, 101, "R6 no crossing");
        run_case(2, 50, 20, 0, 100, "R5 equal counts as crossing");
        run_case(2, 50, 20, 0, 4095, "R6 no crossing");
        pat = 0;
        repeat (300) @(negedge clk);

        // overflow: engine stalled, burst of six triggers
        @(negedge clk); #1;
        cfg_mode = 2'd1; cfg_lat = 11'd10; cfg_width = 11'd4;
        cfg_ped = 12'd0; cfg_thr = 12'd0;
        out_ready = 1'b0;
        fire(t0);
        repeat (10) @(negedge clk);
        #2;
        chk(!ovf, "R8 ovf before burst", int'(ovf), 0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            trig = 1'b1;
            tb_n[k] = n_cur;
        end
        @(negedge clk); #1;
        trig = 1'b0;
        @(negedge clk); #2;
        chk(ovf, "R8 ovf after drop", int'(ovf), 1);
        // R9: word held while stalled
        chk(out_valid && out_tnum == TNW'(exp_tnum), "R9 held word", int'(out_tnum), exp_tnum);
        check_one(1, t0, 10, 4, 0, 0, "R8 stalled job sum");
        exp_tnum++;
        for (int k = 0; k < 4; k++) begin
            check_one(1, tb_n[k], 10, 4, 0, 0, "R8 queued job sum");
            exp_tnum++;
        end
        stop_ready();
        repeat (40) @(negedge clk);
        #2;
        chk(!out_valid, "R8 dropped triggers silent", int'(out_valid), 0);
        chk(ovf, "R8 ovf sticky", int'(ovf), 1);
        run_case(1, 10, 4, 0, 0, "R7 numbering after drops");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule